// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder and Control Generator

This block turns the two opcode fields of a 32-bit instruction into the control strobes that a single-cycle datapath needs. It takes the 6-bit primary opcode and the 6-bit function code. It recognises a subset of 22 instructions: R-format arithmetic and logic, immediate arithmetic and logic, load and store word, three conditional branches, and four unconditional transfers.

The decoding has two stages, and both are combinational. First, each 6-bit field drives its own 6-to-64 one-hot decoder. Their outputs are combined into a one-hot vector that names the instruction. Second, the control strobes are built as ORs of those identity terms, grouped into an arithmetic class, a logic class and an immediate class. Any encoding outside the subset raises an illegal flag, and every strobe stays inactive.

Top module: `instrDecoder`

## Requirements
- R1: `instId` is one-hot for every recognised instruction and all zero otherwise. Bit order, with primary opcode in brackets: 0 add, 1 sub, 2 slt, 3 and, 4 or, 5 xor, 6 nor, 7 jr, 8 syscall (all [0], with function codes 32, 34, 42, 36, 37, 38, 39, 8, 12), 9 lui [15], 10 addi [8], 11 slti [10], 12 andi [12], 13 ori [13], 14 xori [14], 15 lw [35], 16 sw [43], 17 j [2], 18 jal [3], 19 bltz [1], 20 beq [4], 21 bne [5]. For a non-zero primary opcode, the function code has no effect.
- R2: `regWrite` is 1 for lui, jal, lw, every arithmetic instruction (add, sub, slt, addi, slti) and every logic instruction (and, or, xor, nor, andi, ori, xori). It is 0 for all others.
- R3: `regDst` is 01 (rd) for R-format register writes, 10 (register 31) for jal, and 00 (rt) otherwise.
- R4: `aluSrc` is 1 for lui, addi, slti, andi, ori, xori, lw and sw. It is 0 otherwise.
- R5: `addSub` is 1 only for sub, slt and slti.
- R6: `fnClass` is 00 for lui, 01 for slt and slti, 10 for add, sub, addi, lw and sw, and 11 for the logic class. `logicFn` is 00 for and/andi, 01 for or/ori, 10 for xor/xori and 11 for nor. Both fields are 00 for every other instruction.
- R7: `dataRead` is 1 only for lw. `dataWrite` is 1 only for sw. They are never 1 at the same time.
- R8: `brType` is 01 for beq, 10 for bne, 11 for bltz, and 00 otherwise.
- R9: `pcSrc` is 01 for j and jal, 10 for jr, 11 for syscall, and 00 otherwise.
- R10: `illegal` is 1 exactly when no instruction is recognised. This covers an unknown primary opcode, and opcode 0 with an unlisted function code. While it is 1, every other output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opField | input | 6 | Primary opcode field |
| fnField | input | 6 | Function code field |
| instId | output | 22 | One-hot instruction identity |
| regWrite | output | 1 | Register file write enable |
| regDst | output | 2 | Destination register select |
| aluSrc | output | 1 | Second ALU operand is the immediate |
| addSub | output | 1 | Adder subtracts |
| fnClass | output | 2 | ALU function class |
| logicFn | output | 2 | Logic unit operation |
| dataRead | output | 1 | Data memory read |
| dataWrite | output | 1 | Data memory write |
| brType | output | 2 | Conditional branch kind |
| pcSrc | output | 2 | Next-PC source select |
| illegal | output | 1 | Encoding outside the subset |

## Verification
The embedded assertions check several properties on every input combination. They check that the identity vector is at most one-hot and that the illegal flag agrees with it. They also check that an illegal encoding never writes a register or memory, that read and write are never both active, and that the destination select never takes its unused code. Only the bench's directed scenarios can show that each field takes the right value for each instruction. The same holds for the claim that the function code is ignored when the primary opcode is non-zero.

// File: rtl/decCtrlPkg.sv
package decCtrlPkg;
  localparam int FIELD_W = 6;
  localparam int NUM_INST = 22;

  typedef enum logic [4:0] {
    I_ADD = 5'd0, I_SUB = 5'd1, I_SLT = 5'd2, I_AND = 5'd3, I_OR = 5'd4,
    I_XOR = 5'd5, I_NOR = 5'd6, I_JR = 5'd7, I_SYSC = 5'd8, I_LUI = 5'd9,
    I_ADDI = 5'd10, I_SLTI = 5'd11, I_ANDI = 5'd12, I_ORI = 5'd13,
    I_XORI = 5'd14, I_LW = 5'd15, I_SW = 5'd16, I_J = 5'd17, I_JAL = 5'd18,
    I_BLTZ = 5'd19, I_BEQ = 5'd20, I_BNE = 5'd21
  } instIdx_e;

  typedef struct packed {
    logic       regWrite;
    logic [1:0] regDst;
    logic       aluSrc;
    logic       addSub;
    logic [1:0] fnClass;
    logic [1:0] logicFn;
    logic       dataRead;
    logic       dataWrite;
    logic [1:0] brType;
    logic [1:0] pcSrc;
  } ctrlStrobes_t;
endpackage

// File: rtl/fieldDecoder.sv
module fieldDecoder
  import decCtrlPkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int NI = NUM_INST
) (
  input  logic [FW-1:0] opField,
  input  logic [FW-1:0] fnField,
  output logic [NI-1:0] instId,
  output logic          illegal
);
  localparam int HOT_N = 1 << FW;
  localparam logic [HOT_N-1:0] OP_MASK =
    (HOT_N'(1) << 15) | (HOT_N'(1) << 8) | (HOT_N'(1) << 10) | (HOT_N'(1) << 12) |
    (HOT_N'(1) << 13) | (HOT_N'(1) << 14) | (HOT_N'(1) << 35) | (HOT_N'(1) << 43) |
    (HOT_N'(1) << 2) | (HOT_N'(1) << 3) | (HOT_N'(1) << 1) | (HOT_N'(1) << 4) |
    (HOT_N'(1) << 5);
  localparam logic [HOT_N-1:0] FN_MASK =
    (HOT_N'(1) << 32) | (HOT_N'(1) << 34) | (HOT_N'(1) << 42) | (HOT_N'(1) << 36) |
    (HOT_N'(1) << 37) | (HOT_N'(1) << 38) | (HOT_N'(1) << 39) | (HOT_N'(1) << 8) |
    (HOT_N'(1) << 12);

  logic [HOT_N-1:0] opHot, fnHot;
  logic rType, opKnown, fnKnown;

  for (genvar g = 0; g < HOT_N; g++) begin : g_hot
    assign opHot[g] = (opField == FW'(g));
    assign fnHot[g] = (fnField == FW'(g));
  end

  assign rType   = opHot[0];
  assign opKnown = |(opHot & OP_MASK);
  assign fnKnown = |(fnHot & FN_MASK);
  assign illegal = !(opKnown || (rType && fnKnown));

  always_comb begin
    instId = '0;
    instId[I_ADD]  = rType & fnHot[32];
    instId[I_SUB]  = rType & fnHot[34];
    instId[I_SLT]  = rType & fnHot[42];
    instId[I_AND]  = rType & fnHot[36];
    instId[I_OR]   = rType & fnHot[37];
    instId[I_XOR]  = rType & fnHot[38];
    instId[I_NOR]  = rType & fnHot[39];
    instId[I_JR]   = rType & fnHot[8];
    instId[I_SYSC] = rType & fnHot[12];
    instId[I_LUI]  = opHot[15];
    instId[I_ADDI] = opHot[8];
    instId[I_SLTI] = opHot[10];
    instId[I_ANDI] = opHot[12];
    instId[I_ORI]  = opHot[13];
    instId[I_XORI] = opHot[14];
    instId[I_LW]   = opHot[35];
    instId[I_SW]   = opHot[43];
    instId[I_J]    = opHot[2];
    instId[I_JAL]  = opHot[3];
    instId[I_BLTZ] = opHot[1];
    instId[I_BEQ]  = opHot[4];
    instId[I_BNE]  = opHot[5];
  end

  always_comb begin
    if (!$isunknown({opField, fnField})) begin
      // R1
      id_onehot_chk: assert ($onehot0(instId));
      // R10
      illegal_agree_chk: assert (illegal == (instId == '0));
    end
  end
endmodule

// File: rtl/ctrlGen.sv
module ctrlGen
  import decCtrlPkg::*;
#(
  parameter int NI = NUM_INST
) (
  input  logic [NI-1:0] instId,
  input  logic          illegal,
  output ctrlStrobes_t  ctrl
);
  logic arithInst, logicInst, immInst, rFmtWrite;

  assign arithInst = instId[I_ADD] | instId[I_SUB] | instId[I_SLT] |
                     instId[I_ADDI] | instId[I_SLTI];
  assign logicInst = instId[I_AND] | instId[I_OR] | instId[I_XOR] | instId[I_NOR] |
                     instId[I_ANDI] | instId[I_ORI] | instId[I_XORI];
  assign immInst   = instId[I_LUI] | instId[I_ADDI] | instId[I_SLTI] |
                     instId[I_ANDI] | instId[I_ORI] | instId[I_XORI];
  assign rFmtWrite = instId[I_ADD] | instId[I_SUB] | instId[I_SLT] | instId[I_AND] |
                     instId[I_OR] | instId[I_XOR] | instId[I_NOR];

  always_comb begin
    ctrl.regWrite  = instId[I_LUI] | arithInst | logicInst | instId[I_LW] | instId[I_JAL];
    ctrl.regDst    = {instId[I_JAL], rFmtWrite};
    ctrl.aluSrc    = immInst | instId[I_LW] | instId[I_SW];
    ctrl.addSub    = instId[I_SUB] | instId[I_SLT] | instId[I_SLTI];
    ctrl.fnClass   = {arithInst & ~(instId[I_SLT] | instId[I_SLTI]) | instId[I_LW] |
                      instId[I_SW] | logicInst,
                      instId[I_SLT] | instId[I_SLTI] | logicInst};
    ctrl.logicFn   = {instId[I_XOR] | instId[I_XORI] | instId[I_NOR],
                      instId[I_OR] | instId[I_ORI] | instId[I_NOR]};
    ctrl.dataRead  = instId[I_LW];
    ctrl.dataWrite = instId[I_SW];
    ctrl.brType    = {instId[I_BNE] | instId[I_BLTZ], instId[I_BEQ] | instId[I_BLTZ]};
    ctrl.pcSrc     = {instId[I_JR] | instId[I_SYSC],
                      instId[I_J] | instId[I_JAL] | instId[I_SYSC]};
  end

  always_comb begin
    if (!$isunknown({instId, illegal})) begin
      // R10
      illegal_quiet_chk: assert (!(illegal && (ctrl.regWrite || ctrl.dataWrite)));
      // R7
      mem_excl_chk: assert (!(ctrl.dataRead && ctrl.dataWrite));
      // R3
      dst_code_chk: assert (ctrl.regDst != 2'b11);
      // R2
      write_src_chk: assert (!ctrl.regWrite || ctrl.regDst != 2'b00 || ctrl.aluSrc);
    end
  end
endmodule

// File: rtl/instrDecoder.sv
module instrDecoder
  import decCtrlPkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int NI = NUM_INST
) (
  input  logic [FW-1:0] opField,
  input  logic [FW-1:0] fnField,
  output logic [NI-1:0] instId,
  output logic          regWrite,
  output logic [1:0]    regDst,
  output logic          aluSrc,
  output logic          addSub,
  output logic [1:0]    fnClass,
  output logic [1:0]    logicFn,
  output logic          dataRead,
  output logic          dataWrite,
  output logic [1:0]    brType,
  output logic [1:0]    pcSrc,
  output logic          illegal
);
  ctrlStrobes_t ctrl;

  fieldDecoder #(.FW(FW), .NI(NI)) u_dec (
    .opField(opField), .fnField(fnField), .instId(instId), .illegal(illegal)
  );

  ctrlGen #(.NI(NI)) u_ctrl (
    .instId(instId), .illegal(illegal), .ctrl(ctrl)
  );

  assign regWrite  = ctrl.regWrite;
  assign regDst    = ctrl.regDst;
  assign aluSrc    = ctrl.aluSrc;
  assign addSub    = ctrl.addSub;
  assign fnClass   = ctrl.fnClass;
  assign logicFn   = ctrl.logicFn;
  assign dataRead  = ctrl.dataRead;
  assign dataWrite = ctrl.dataWrite;
  assign brType    = ctrl.brType;
  assign pcSrc     = ctrl.pcSrc;
endmodule

// File: tb/instrDecoder_bench.sv
module instrDecoder_bench;
  logic clk = 1'b0;
  logic [5:0] opField, fnField;
  logic [21:0] instId;
  logic regWrite, aluSrc, addSub, dataRead, dataWrite, illegal;
  logic [1:0] regDst, fnClass, logicFn, brType, pcSrc;
  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  instrDecoder u_instrDecoder (
    .opField(opField), .fnField(fnField), .instId(instId), .regWrite(regWrite),
    .regDst(regDst), .aluSrc(aluSrc), .addSub(addSub), .fnClass(fnClass),
    .logicFn(logicFn), .dataRead(dataRead), .dataWrite(dataWrite),
    .brType(brType), .pcSrc(pcSrc), .illegal(illegal)
  );

  task automatic check(string tag, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s op=%0d fn=%0d actual=%0h expected=%0h", tag, opField, fnField, act, exp);
    end
  endtask

  // idx < 0 means no instruction recognised
  task automatic runOne(input int op, input int fn, input int idx,
                        input int rw, input int rd, input int as, input int asb,
                        input int fc, input int lf, input int dr, input int dw,
                        input int bt, input int ps);
    @(posedge clk);
    opField = 6'(op);
    fnField = 6'(fn);
    @(negedge clk);
    check("R1 instId", int'(instId), (idx < 0) ? 0 : (1 << idx));
    check("R2 regWrite", int'(regWrite), rw);
    check("R3 regDst", int'(regDst), rd);
    check("R4 aluSrc", int'(aluSrc), as);
    check("R5 addSub", int'(addSub), asb);
    check("R6 fnClass", int'(fnClass), fc);
    check("R6 logicFn", int'(logicFn), lf);
    check("R7 dataRead", int'(dataRead), dr);
    check("R7 dataWrite", int'(dataWrite), dw);
    check("R8 brType", int'(brType), bt);
    check("R9 pcSrc", int'(pcSrc), ps);
    check("R10 illegal", int'(illegal), (idx < 0) ? 1 : 0);
  endtask

  task automatic testRFormat();
    runOne(0, 32, 0, 1, 1, 0, 0, 2, 0, 0, 0, 0, 0);
    runOne(0, 34, 1, 1, 1, 0, 1, 2, 0, 0, 0, 0, 0);
    runOne(0, 42, 2, 1, 1, 0, 1, 1, 0, 0, 0, 0, 0);
    runOne(0, 36, 3, 1, 1, 0, 0, 3, 0, 0, 0, 0, 0);
    runOne(0, 37, 4, 1, 1, 0, 0, 3, 1, 0, 0, 0, 0);
    runOne(0, 38, 5, 1, 1, 0, 0, 3, 2, 0, 0, 0, 0);
    runOne(0, 39, 6, 1, 1, 0, 0, 3, 3, 0, 0, 0, 0);
  endtask

  task automatic testImmediate();
    runOne(15, 0, 9, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    runOne(8, 0, 10, 1, 0, 1, 0, 2, 0, 0, 0, 0, 0);
    runOne(10, 0, 11, 1, 0, 1, 1, 1, 0, 0, 0, 0, 0);
    runOne(12, 0, 12, 1, 0, 1, 0, 3, 0, 0, 0, 0, 0);
    runOne(13, 0, 13, 1, 0, 1, 0, 3, 1, 0, 0, 0, 0);
    runOne(14, 0, 14, 1, 0, 1, 0, 3, 2, 0, 0, 0, 0);
    // R1: fn ignored for non-zero op
    runOne(14, 34, 14, 1, 0, 1, 0, 3, 2, 0, 0, 0, 0);
  endtask

  task automatic testMemory();
    runOne(35, 0, 15, 1, 0, 1, 0, 2, 0, 1, 0, 0, 0);
    runOne(43, 0, 16, 0, 0, 1, 0, 2, 0, 0, 1, 0, 0);
    runOne(43, 42, 16, 0, 0, 1, 0, 2, 0, 0, 1, 0, 0);
  endtask

  task automatic testTransfer();
    runOne(2, 0, 17, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    runOne(3, 0, 18, 1, 2, 0, 0, 0, 0, 0, 0, 0, 1);
    runOne(0, 8, 7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2);
    runOne(0, 12, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
    runOne(1, 0, 19, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0);
    runOne(4, 0, 20, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    runOne(5, 0, 21, 0, 0, 0, 0, 0, 0, 0, 0, 2, 0);
  endtask

  task automatic testIllegal();
    runOne(0, 33, -1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    runOne(0, 63, -1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    runOne(6, 0, -1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    runOne(63, 32, -1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10: sweep every opcode, only listed ones are legal
    for (int op = 1; op < 64; op++) begin
      bit known;
      known = (op == 1) || (op == 2) || (op == 3) || (op == 4) || (op == 5) ||
              (op == 8) || (op == 10) || (op == 12) || (op == 13) || (op == 14) ||
              (op == 15) || (op == 35) || (op == 43);
      @(posedge clk);
      opField = 6'(op);
      fnField = 6'd0;
      @(negedge clk);
      check("R10 op sweep", int'(illegal), known ? 0 : 1);
    end
  endtask

  initial begin
    opField = 6'd0;
    fnField = 6'd0;
    @(negedge clk);
    // R10: idle encoding op=0 fn=0 is illegal
    check("R10 initial", int'(illegal), 1);
    check("R2 initial", int'(regWrite), 0);
    testRFormat();
    testImmediate();
    testMemory();
    testTransfer();
    testIllegal();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule